// File: doc/BRIEF.md
# Fixed-Length Management Message Framer

This block assembles one management message of a fixed 267 bytes and hands it, one byte at a time, to a byte-wide serial transmitter. Software first fills a small register window: a message kind, a command code, a result byte, a payload length, a 32-bit task identifier and up to 250 payload bytes. A single-cycle start strobe then launches the frame. The framer walks through the frame's fields in a fixed order, pads the unused part of the payload with zeros, and folds a running XOR checksum over the bytes it emits. It keeps `busy` high until the transmitter has taken the last byte.

The frame is laid out at these byte offsets:

| Offsets | Field |
|---|---|
| 0-3 | header magic 0xA55AAA55 |
| 4-7 | task identifier |
| 8 | kind |
| 9 | command |
| 10 | result |
| 11 | length |
| 12-261 | payload area |
| 262 | checksum |
| 263-266 | tail magic 0xBDBABDBA |

Every multi-byte field is sent least-significant byte first. Kinds are request=1, reply=2 and notify=3. Commands are power-off=1, warm reboot=2, board info=3, LED=4, sensor info=5, board status=6, power info=7 and cold restart=8. Shutdown and cold-restart notices carry length 0.

Top module: `mgmt_frame_tx`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `done` and `len_err` are all 0.
- R2: A frame accepted by `start` puts exactly 267 bytes on `tx_data`. The kind, command, result and length go out at offsets 8, 9, 10 and 11, and the stored payload bytes start at offset 12.
- R3: The header magic goes out as 0x55, 0xAA, 0x5A, 0xA5 at offsets 0-3. The task identifier follows least-significant byte first at offsets 4-7. The tail goes out as 0xBA, 0xBD, 0xBA, 0xBD at offsets 263-266.
- R4: The byte at offset 262 is the XOR, starting from 0, of the kind, command and effective length bytes and payload bytes 0 to length-1. The magics, the task identifier, the result byte and the padding are not included.
- R5: Every payload-area byte at index equal to or above the effective length is sent as 0x00.
- R6: A length above 250 is sent as 250 and treated as 250 for the checksum and the padding. A start that launches such a frame sets `len_err`, which stays set until reset.
- R7: A `start` while `busy` is high is ignored. This holds as well in the cycle in which the final byte is accepted. No new frame begins and the byte sequence is not disturbed.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.
- R9: `done` is high for exactly one cycle, the cycle after the final tail byte is accepted, and `busy` is low from that cycle on.
- R10: Writes while `busy` is high change nothing. Write addresses: 0x000-0x0F9 are payload bytes, 0x100 is the kind, 0x101 the command, 0x102 the result, 0x103 the length, and 0x104-0x107 the task identifier bytes from least to most significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register window write strobe |
| wr_addr | input | 9 | Register window address |
| wr_data | input | 8 | Register window write byte |
| start | input | 1 | Launch strobe for one frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the final byte |
| len_err | output | 1 | Sticky flag for an oversized length |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |

## Verification
Two events can meet in one cycle: a new `start` strobe and the acceptance of the final tail byte, which ends the current frame. The bench raises `start` in exactly the cycle it accepts byte 266. It then expects the `done` pulse with `busy` low, followed by an idle `tx_valid`, and no second frame. The bench also issues a `start` and register writes in the middle of a frame that is stalled by an irregular `tx_ready` pattern. It judges them against a frame rebuilt byte for byte from its own model of the layout and the checksum.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;

  localparam logic [31:0] HDR_MAGIC  = 32'hA55A_AA55;
  localparam logic [31:0] TAIL_MAGIC = 32'hBDBA_BDBA;

  // Fixed field offsets ahead of the payload area
  localparam int OFF_TASK = 4;
  localparam int OFF_KIND = 8;
  localparam int OFF_CMD  = 9;
  localparam int OFF_RES  = 10;
  localparam int OFF_LEN  = 11;
  localparam int OFF_DATA = 12;
  // Bytes outside the payload area: 12 leading, checksum, 4 trailing
  localparam int FIXED_BYTES = OFF_DATA + 1 + 4;

  typedef enum logic [7:0] {
    KIND_REQUEST = 8'd1,
    KIND_REPLY   = 8'd2,
    KIND_NOTIFY  = 8'd3
  } msg_kind_e;

  typedef enum logic [7:0] {
    CMD_POWER_OFF  = 8'd1,
    CMD_WARM_BOOT  = 8'd2,
    CMD_BOARD_INFO = 8'd3,
    CMD_LED        = 8'd4,
    CMD_SENSORS    = 8'd5,
    CMD_STATUS     = 8'd6,
    CMD_POWER_INFO = 8'd7,
    CMD_COLD_BOOT  = 8'd8
  } msg_cmd_e;

  // Pick byte k of a 32-bit word, low byte first
  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] k);
    return w[8*k +: 8];
  endfunction

  // Saturate a requested payload length to the payload area size
  function automatic logic [7:0] clamp_len(input logic [7:0] l, input int unsigned lim);
    return (l > 8'(lim)) ? 8'(lim) : l;
  endfunction

  function automatic logic len_over(input logic [7:0] l, input int unsigned lim);
    return l > 8'(lim);
  endfunction

endpackage

// File: rtl/mgmt_frame_store.sv
module mgmt_frame_store #(
  parameter int DATA_BYTES = 250,
  parameter int ADDR_W     = 9,
  localparam int DW        = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [DW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic [7:0]        kind_q,
  output logic [7:0]        cmd_q,
  output logic [7:0]        res_q,
  output logic [7:0]        len_raw_q,
  output logic [31:0]       task_q
);

  logic [7:0] mem [DATA_BYTES];

  logic pl_sel;
  logic hd_sel;

  assign pl_sel = wr_en && !lock && !wr_addr[ADDR_W-1] &&
                  (wr_addr < ADDR_W'(DATA_BYTES));
  assign hd_sel = wr_en && !lock && wr_addr[ADDR_W-1] &&
                  (wr_addr[ADDR_W-2:3] == '0);

  always_ff @(posedge clk) begin
    if (pl_sel) mem[wr_addr[DW-1:0]] <= wr_data;
  end

  assign rd_data = (rd_idx < DW'(DATA_BYTES)) ? mem[rd_idx] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= '0;
      cmd_q     <= '0;
      res_q     <= '0;
      len_raw_q <= '0;
      task_q    <= '0;
    end else if (hd_sel) begin
      case (wr_addr[2:0])
        3'd0: kind_q    <= wr_data;
        3'd1: cmd_q     <= wr_data;
        3'd2: res_q     <= wr_data;
        3'd3: len_raw_q <= wr_data;
        default: task_q[8*wr_addr[1:0] +: 8] <= wr_data;
      endcase
    end
  end

  AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock && wr_en |=> $stable(kind_q) && $stable(cmd_q) && $stable(res_q) &&
                      $stable(len_raw_q) && $stable(task_q)) // R10
    else $error("header register changed while locked");

endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_frame_pkg::*;
#(
  parameter int DATA_BYTES = 250,
  localparam int FB        = DATA_BYTES + FIXED_BYTES,
  localparam int IW        = $clog2(FB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fire,
  input  logic [7:0]    len_raw,
  output logic          launch,
  output logic          busy,
  output logic          done,
  output logic          len_err,
  output logic [IW-1:0] idx,
  output logic [7:0]    len_q
);

  localparam logic [IW-1:0] LAST = IW'(FB - 1);

  logic last_fire;

  assign launch    = start && !busy;
  assign last_fire = fire && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      len_err <= 1'b0;
      idx     <= '0;
      len_q   <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy  <= 1'b1;
        idx   <= '0;
        len_q <= clamp_len(len_raw, DATA_BYTES);
        if (len_over(len_raw, DATA_BYTES)) len_err <= 1'b1;
      end else if (fire) begin
        if (last_fire) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  AST_HOLD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fire |=> $stable(idx)) // R8
    else $error("position moved without acceptance");
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (idx != '0) |=> idx != '0) // R7
    else $error("start restarted a running frame");
  AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> done && !busy) // R9
    else $error("no done after final byte");
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) // R9
    else $error("done longer than one cycle");
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err) // R6
    else $error("length error flag cleared");
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> len_q <= 8'(DATA_BYTES)) // R6
    else $error("effective length above payload area");

endmodule

// File: rtl/mgmt_frame_bytes.sv
module mgmt_frame_bytes
  import mgmt_frame_pkg::*;
#(
  parameter int DATA_BYTES = 250,
  localparam int FB        = DATA_BYTES + FIXED_BYTES,
  localparam int IW        = $clog2(FB),
  localparam int DW        = $clog2(DATA_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          busy,
  input  logic          fire,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    len_q,
  input  logic [7:0]    kind_q,
  input  logic [7:0]    cmd_q,
  input  logic [7:0]    res_q,
  input  logic [31:0]   task_q,
  input  logic [7:0]    rd_data,
  output logic [DW-1:0] rd_idx,
  output logic [7:0]    tx_byte
);

  localparam int OFF_CK   = OFF_DATA + DATA_BYTES;
  localparam int OFF_TAIL = OFF_CK + 1;

  logic [7:0]    ck_q;
  logic [IW-1:0] didx;
  logic [IW-1:0] tidx;
  logic          in_data;
  logic          live_data;
  logic          covered;

  assign didx      = idx - IW'(OFF_DATA);
  assign tidx      = idx - IW'(OFF_TAIL);
  assign rd_idx    = didx[DW-1:0];
  assign in_data   = (idx >= IW'(OFF_DATA)) && (idx < IW'(OFF_CK));
  assign live_data = in_data && (didx < IW'(len_q));
  assign covered   = (idx == IW'(OFF_KIND)) || (idx == IW'(OFF_CMD)) ||
                     (idx == IW'(OFF_LEN)) || live_data;

  always_comb begin
    if (idx < IW'(OFF_TASK))       tx_byte = word_byte(HDR_MAGIC, idx[1:0]);
    else if (idx < IW'(OFF_KIND))  tx_byte = word_byte(task_q, idx[1:0]);
    else if (idx == IW'(OFF_KIND)) tx_byte = kind_q;
    else if (idx == IW'(OFF_CMD))  tx_byte = cmd_q;
    else if (idx == IW'(OFF_RES))  tx_byte = res_q;
    else if (idx == IW'(OFF_LEN))  tx_byte = len_q;
    else if (in_data)              tx_byte = live_data ? rd_data : 8'h00;
    else if (idx == IW'(OFF_CK))   tx_byte = ck_q;
    else                           tx_byte = word_byte(TAIL_MAGIC, tidx[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ck_q <= '0;
    else if (launch)           ck_q <= '0;
    else if (fire && covered)  ck_q <= ck_q ^ tx_byte;
  end

  AST_CK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (idx >= IW'(OFF_CK)) |=> $stable(ck_q)) // R4
    else $error("checksum changed after payload area");
  AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> tx_byte == 8'h55) // R3
    else $error("frame did not open with header low byte");

endmodule

// File: rtl/mgmt_frame_tx.sv
module mgmt_frame_tx
  import mgmt_frame_pkg::*;
#(
  parameter int DATA_BYTES = 250,
  parameter int ADDR_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              len_err,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);

  localparam int FB = DATA_BYTES + FIXED_BYTES;
  localparam int IW = $clog2(FB);
  localparam int DW = $clog2(DATA_BYTES);

  logic          fire;
  logic          launch;
  logic [IW-1:0] idx;
  logic [7:0]    len_q;
  logic [7:0]    kind_q, cmd_q, res_q, len_raw_q;
  logic [31:0]   task_q;
  logic [DW-1:0] rd_idx;
  logic [7:0]    rd_data;

  assign tx_valid = busy;
  assign fire     = tx_valid && tx_ready;

  mgmt_frame_store #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst_n(rst_n), .lock(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .kind_q(kind_q),
    .cmd_q(cmd_q), .res_q(res_q), .len_raw_q(len_raw_q), .task_q(task_q)
  );

  mgmt_frame_seq #(.DATA_BYTES(DATA_BYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fire(fire), .len_raw(len_raw_q),
    .launch(launch), .busy(busy), .done(done), .len_err(len_err),
    .idx(idx), .len_q(len_q)
  );

  mgmt_frame_bytes #(.DATA_BYTES(DATA_BYTES)) bytes_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .fire(fire),
    .idx(idx), .len_q(len_q), .kind_q(kind_q), .cmd_q(cmd_q), .res_q(res_q),
    .task_q(task_q), .rd_data(rd_data), .rd_idx(rd_idx), .tx_byte(tx_data)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid) // R9
    else $error("valid during done pulse");

endmodule

// File: tb/mgmt_frame_tx_tb.sv
module mgmt_frame_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 250;
  localparam int FB = 267;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic       tx_ready = 1'b0;
  logic       busy, done, len_err, tx_valid;
  logic [7:0] tx_data;

  mgmt_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .busy(busy), .done(done),
    .len_err(len_err), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // bench model of the stored fields
  logic [7:0]  pl [D];
  logic [7:0]  m_kind, m_cmd, m_res, m_len;
  logic [31:0] m_task;
  logic [7:0]  got [FB];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] k, input logic [7:0] c, input logic [7:0] r,
                      input logic [7:0] l, input logic [31:0] t, input int seed);
    for (int i = 0; i < D; i++) begin
      pl[i] = 8'((i * 13 + seed) & 255);
      wr(9'(i), pl[i]);
    end
    m_kind = k; m_cmd = c; m_res = r; m_len = l; m_task = t;
    wr(9'h100, k); wr(9'h101, c); wr(9'h102, r); wr(9'h103, l);
    for (int b = 0; b < 4; b++) wr(9'(9'h104 + b), t[8*b +: 8]);
  endtask

  function automatic int eff_len();
    return (m_len > 8'(D)) ? D : int'(m_len);
  endfunction

  function automatic logic [7:0] exp_ck();
    logic [7:0] c;
    c = m_kind ^ m_cmd ^ 8'(eff_len());
    for (int j = 0; j < eff_len(); j++) c = c ^ pl[j];
    return c;
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    logic [31:0] hdr, tl;
    hdr = 32'hA55AAA55; tl = 32'hBDBABDBA;
    if (i < 4)        return hdr[8*i +: 8];
    else if (i < 8)   return m_task[8*(i-4) +: 8];
    else if (i == 8)  return m_kind;
    else if (i == 9)  return m_cmd;
    else if (i == 10) return m_res;
    else if (i == 11) return 8'(eff_len());
    else if (i < 262) return ((i - 12) < eff_len()) ? pl[i-12] : 8'h00;
    else if (i == 262) return exp_ck();
    else               return tl[8*(i-263) +: 8];
  endfunction

  function automatic string tag_of(input int i);
    if (i < 8 || i > 262) return "R3";
    if (i == 262) return "R4";
    if (i >= 12 && (i - 12) >= eff_len()) return "R5";
    return "R2";
  endfunction

  // mode 0: always ready, 1: alternate, 2: pseudo-random
  task automatic run_frame(input int mode, input bit poke);
    int n = 0;
    int guard = 0;
    bit stalled = 0;
    int hold_checks = 0;
    logic [7:0] held = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (n < FB && guard < 5000) begin
      if (guard > 0) @(negedge clk);
      guard++;
      start = 1'b0; wr_en = 1'b0;
      case (mode)
        0: tx_ready = 1'b1;
        1: tx_ready = guard[0];
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          tx_ready = lfsr[0] | lfsr[3];
        end
      endcase
      if (poke && n == 20) begin wr_en = 1'b1; wr_addr = 9'h000; wr_data = 8'hEE; end
      if (poke && n == 40) begin wr_en = 1'b1; wr_addr = 9'h103; wr_data = 8'h09; end
      if (poke && n == 100) start = 1'b1; // R7 mid-frame start
      #1;
      if (stalled && hold_checks < 8) begin
        chk(tx_data == held, "R8 hold", tx_data, held);
        hold_checks++;
      end
      stalled = 0;
      if (tx_valid && tx_ready) begin
        got[n] = tx_data;
        if (poke && n == FB - 1) start = 1'b1; // R7 start on final accept
        n++;
      end else if (tx_valid) begin
        stalled = 1; held = tx_data;
      end
    end
    chk(n == FB, "R2 byte count", n, FB);
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0; tx_ready = 1'b0;
    #1;
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(busy == 1'b0, "R9 busy low", busy, 0);
    @(negedge clk); #1;
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(tx_valid == 1'b0, "R7 no relaunch", tx_valid, 0);
    for (int i = 0; i < n; i++)
      chk(got[i] == exp_byte(i), tag_of(i), got[i], exp_byte(i));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0 && tx_valid == 1'b0, "R1 reset idle", {busy, tx_valid}, 0);
    chk(done == 1'b0 && len_err == 1'b0, "R1 reset flags", {done, len_err}, 0);
    @(negedge clk); rst_n = 1'b1;

    load(8'd3, 8'd1, 8'd0, 8'd0, 32'h11223344, 5);     // notify power-off
    run_frame(0, 0);
    load(8'd3, 8'd8, 8'd0, 8'd0, 32'hCAFEF00D, 9);     // notify cold restart
    run_frame(1, 0);
    load(8'd1, 8'd3, 8'h5A, 8'd1, 32'h00000001, 77);   // R10 writes during frame
    run_frame(2, 1);
    load(8'd2, 8'd6, 8'h81, 8'd7, 32'h89ABCDEF, 3);
    run_frame(0, 0);
    chk(len_err == 1'b0, "R6 no error for legal length", len_err, 0);
    load(8'd1, 8'd5, 8'h00, 8'd250, 32'h0F0F0F0F, 200);
    run_frame(2, 0);
    chk(len_err == 1'b0, "R6 full length legal", len_err, 0);
    load(8'd1, 8'd7, 8'h33, 8'd251, 32'h12345678, 31); // R6 clamp
    run_frame(0, 0);
    chk(len_err == 1'b1, "R6 error raised", len_err, 1);
    load(8'd2, 8'd4, 8'h44, 8'd5, 32'hDEADBEEF, 61);
    run_frame(1, 0);
    chk(len_err == 1'b1, "R6 error sticky", len_err, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule